// File: doc/BRIEF.md
# Pulse Width Measurement Channel

This block is one channel of a multi-channel pulse timing device. On a trigger it sends out an interrogation pulse whose width is set in periods of a slow timebase. It then measures how long the returning pulse stays high by counting periods of the fast clock. A trigger comes from a frame strobe that all channels share, or from this channel's own software bit. A full device places three of these channels side by side.

The returning pulse is asynchronous, so it passes through a synchronizer before any logic uses it. The width counter has two stages. A narrow low stage runs at full rate, and its carry advances a wider high stage. With the default widths (6 + 12) the result is 18 bits. The counter saturates at all ones and raises a sticky overflow flag instead of wrapping. A busy flag stays high from the trigger until the measured pulse has ended. The count holds its value until the next trigger.

Top module: `pulse_width_channel`

## Requirements
- R1: After reset `trig_o`, `busy_o` and `ovf_o` are 0 and `width_o` is 0.
- R2: While the channel is idle, a high `frame_trig_i` or a high `sw_trig_i` at a clock edge starts a cycle. In the next cycle `trig_o` and `busy_o` are 1.
- R3: `trig_o` stays high until `trig_width_i` slow-enable pulses have occurred, counted from the cycle after the start. With `slow_en_i` held at 1, it is high for exactly `trig_width_i` clock cycles (1 to 255).
- R4: A `trig_width_i` of 0 gives the same pulse as a value of 1.
- R5: `width_o` ends equal to the number of fast clock cycles for which the synchronized input was high. Measurement begins at the first rising edge after the trigger.
- R6: The count is correct across the carry between the low stage (6 bits) and the high stage, for example at 63, 64, 65 and 128.
- R7: `busy_o` clears a fixed number of cycles after the input falls. `width_o` then holds its value until the next trigger.
- R8: A new trigger clears `width_o` to 0 and `ovf_o` to 0.
- R9: A pulse longer than the counter range leaves `width_o` at all ones and sets `ovf_o`. `ovf_o` stays set until the next trigger. A pulse of exactly all-ones length does not set `ovf_o`.
- R10: Triggers that arrive while `busy_o` is 1 are ignored. No trigger pulse is produced and the count is not cleared.
- R11: If the input is already high when the trigger arrives, that pulse is not measured. Counting starts at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast measurement clock |
| rst_ni | input | 1 | Active-low reset |
| slow_en_i | input | 1 | One-cycle enable marking each slow timebase period |
| frame_trig_i | input | 1 | Shared frame trigger strobe |
| sw_trig_i | input | 1 | Per-channel software trigger bit |
| trig_width_i | input | TW_W (8) | Trigger pulse width in slow periods, 0 acts as 1 |
| pulse_i | input | 1 | Asynchronous returning pulse |
| trig_o | output | 1 | Interrogation pulse output |
| width_o | output | LO_W+HI_W (18) | Measured width in fast clock cycles |
| ovf_o | output | 1 | Sticky saturation flag |
| busy_o | output | 1 | High from trigger to end of measurement |

## Verification
The states hardest to reach are saturation and the stage carries. At the default width, saturation needs a pulse of about 262k cycles. The bench therefore narrows the high stage to 4 bits, which brings the limit to 1023. It then drives pulses of exactly 1023 and of 1100 cycles. The other hard cases are a trigger arriving in the middle of a measurement and an input that is already high when the trigger arrives. For these, directed sequences hold the input level across the trigger and issue a software trigger while a pulse is being counted.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_MEAS  = 2'd2
    } meas_st_e;
endpackage

// File: rtl/pwc_sync.sv
module pwc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.sh = {r_q.sh[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign level_o = r_q.sh[STAGES-1];
    assign rise_o  = r_q.sh[STAGES-1] & ~r_q.sh[STAGES];
    assign fall_o  = ~r_q.sh[STAGES-1] & r_q.sh[STAGES];
endmodule

// File: rtl/pwc_trig_gen.sv
module pwc_trig_gen #(
    parameter int TW_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic            slow_en_i,
    input  logic [TW_W-1:0] width_i,
    output logic            pulse_o
);
    typedef struct packed {
        logic            active;
        logic [TW_W-1:0] rem;
    } tg_t;

    tg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.active = 1'b1;
            r_d.rem    = (width_i == '0) ? TW_W'(1) : width_i;
        end else if (r_q.active && slow_en_i) begin
            if (r_q.rem <= TW_W'(1)) r_d.active = 1'b0;
            else                     r_d.rem    = r_q.rem - TW_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign pulse_o = r_q.active;

    // R2
    trig_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pulse_o) |-> $past(start_i));
    // R3
    trig_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pulse_o && !start_i && !slow_en_i) |=> pulse_o);
endmodule

// File: rtl/pwc_width_ctr.sv
module pwc_width_ctr #(
    parameter int LO_W = 6,
    parameter int HI_W = 12
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 clr_i,
    input  logic                 inc_i,
    output logic [LO_W+HI_W-1:0] cnt_o,
    output logic                 ovf_o
);
    localparam int CW = LO_W + HI_W;
    localparam logic [CW-1:0] CMAX = '1;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
        logic            ovf;
    } wc_t;

    wc_t  r_d, r_q;
    logic full;

    assign full = (&r_q.lo) & (&r_q.hi);

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d = '0;
        end else if (inc_i) begin
            if (full) begin
                r_d.ovf = 1'b1;
            end else begin
                r_d.lo = r_q.lo + LO_W'(1);
                if (&r_q.lo) r_d.hi = r_q.hi + HI_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign cnt_o = {r_q.hi, r_q.lo};
    assign ovf_o = r_q.ovf;

    // R9
    sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_o == CMAX && !clr_i) |=> (cnt_o == CMAX));
    // R5
    monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> (cnt_o >= $past(cnt_o)));
    // R8
    clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_o == '0 && !ovf_o));
    // R9
    ovf_at_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_o) |-> (cnt_o == CMAX));
endmodule

// File: rtl/pulse_width_channel.sv
module pulse_width_channel
    import pwc_pkg::*;
#(
    parameter int TW_W        = 8,
    parameter int LO_W        = 6,
    parameter int HI_W        = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 slow_en_i,
    input  logic                 frame_trig_i,
    input  logic                 sw_trig_i,
    input  logic [TW_W-1:0]      trig_width_i,
    input  logic                 pulse_i,
    output logic                 trig_o,
    output logic [LO_W+HI_W-1:0] width_o,
    output logic                 ovf_o,
    output logic                 busy_o
);
    typedef struct packed {
        meas_st_e st;
    } ch_t;

    ch_t  r_d, r_q;
    logic lvl, rise, fall;
    logic start, cnt_en;

    pwc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pulse_i),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    assign start  = (frame_trig_i | sw_trig_i) & (r_q.st == ST_IDLE);
    assign cnt_en = lvl & ((r_q.st == ST_MEAS) | ((r_q.st == ST_ARMED) & rise));

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE:  if (start) r_d.st = ST_ARMED;
            ST_ARMED: if (rise)  r_d.st = ST_MEAS;
            ST_MEAS:  if (fall)  r_d.st = ST_IDLE;
            default:             r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{st: ST_IDLE};
        else         r_q <= r_d;
    end

    pwc_trig_gen #(.TW_W(TW_W)) u_trig (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start),
        .slow_en_i (slow_en_i),
        .width_i   (trig_width_i),
        .pulse_o   (trig_o)
    );

    pwc_width_ctr #(.LO_W(LO_W), .HI_W(HI_W)) u_ctr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (start),
        .inc_i  (cnt_en),
        .cnt_o  (width_o),
        .ovf_o  (ovf_o)
    );

    assign busy_o = (r_q.st != ST_IDLE);

    // R7
    busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> $past(fall));
    // R10
    no_retrig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> !$rose(trig_o));
    // R7
    hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !frame_trig_i && !sw_trig_i) |=> $stable(width_o));
endmodule

// File: tb/sim_pulse_width_channel.sv
module sim_pulse_width_channel;
    localparam int TW_W = 8;
    localparam int LO_W = 6;
    localparam int HI_W = 4;
    localparam int CW   = LO_W + HI_W;
    localparam int MAXC = (1 << CW) - 1;
    localparam int NV   = 8;

    // {trig width, pulse length, expected trig length, expected count, use frame}
    localparam int VEC [NV][5] = '{
        '{5,   10,  5,   10,  0},
        '{0,   1,   1,   1,   1},
        '{1,   63,  1,   63,  0},
        '{12,  64,  12,  64,  1},
        '{255, 65,  255, 65,  0},
        '{3,   128, 3,   128, 1},
        '{7,   200, 7,   200, 0},
        '{2,   1023,2,   1023,1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_en = 1'b1, frame_trig = 1'b0, sw_trig = 1'b0, pulse = 1'b0;
    logic [TW_W-1:0] tw = '0;
    logic trig, ovf, busy;
    logic [CW-1:0] width;
    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pulse_width_channel #(.TW_W(TW_W), .LO_W(LO_W), .HI_W(HI_W)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .slow_en_i(slow_en),
        .frame_trig_i(frame_trig), .sw_trig_i(sw_trig),
        .trig_width_i(tw), .pulse_i(pulse),
        .trig_o(trig), .width_o(width), .ovf_o(ovf), .busy_o(busy));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fire(input bit use_frame);
        if (use_frame) frame_trig = 1'b1; else sw_trig = 1'b1;
        @(negedge clk);
        frame_trig = 1'b0; sw_trig = 1'b0;
    endtask

    task automatic trig_len(output int n);
        n = 0;
        while (trig && n < 2000) begin n++; @(negedge clk); end
    endtask

    task automatic drive_pulse(input int len);
        pulse = 1'b1;
        repeat (len) @(negedge clk);
        pulse = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 trig", trig, 0); chk("R1 busy", busy, 0);
        chk("R1 ovf", ovf, 0);   chk("R1 width", width, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            tw = TW_W'(VEC[i][0]);
            fire(VEC[i][4] != 0);
            chk("R2 busy after trigger", busy, 1);
            chk("R8 width cleared", width, 0);
            trig_len(n);
            chk((VEC[i][0] == 0) ? "R4 zero width" : "R3 trig width", n, VEC[i][2]);
            drive_pulse(VEC[i][1]);
            chk("R5 R6 count", width, VEC[i][3]);
            chk("R7 busy clear", busy, 0);
            chk("R9 no ovf", ovf, 0);
        end

        // R7 count holds while idle
        repeat (20) @(negedge clk);
        chk("R7 hold", width, 1023);

        // R9 saturation and sticky overflow
        tw = 8'd1;
        fire(0);
        @(negedge clk);
        drive_pulse(1100);
        chk("R9 saturated", width, MAXC);
        chk("R9 ovf set", ovf, 1);
        repeat (10) @(negedge clk);
        chk("R9 ovf sticky", ovf, 1);
        fire(1);
        chk("R8 ovf cleared", ovf, 0);
        chk("R8 width cleared", width, 0);
        @(negedge clk);
        drive_pulse(4);
        chk("R5 short", width, 4);

        // R10 trigger during measurement ignored
        tw = 8'd2;
        fire(0);
        repeat (4) @(negedge clk);
        pulse = 1'b1;
        repeat (10) @(negedge clk);
        sw_trig = 1'b1; frame_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0; frame_trig = 1'b0;
        chk("R10 no trig", trig, 0);
        repeat (3) @(negedge clk);
        chk("R10 no clear", width >= 10, 1);
        repeat (7) @(negedge clk);
        pulse = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 width", width, 21);

        // R11 input already high at trigger
        pulse = 1'b1;
        repeat (5) @(negedge clk);
        fire(0);
        repeat (10) @(negedge clk);
        chk("R11 not counting", width, 0);
        pulse = 1'b0;
        repeat (6) @(negedge clk);
        chk("R11 still busy", busy, 1);
        chk("R11 width zero", width, 0);
        drive_pulse(7);
        chk("R11 width", width, 7);
        chk("R11 done", busy, 0);

        // R3 with slow enable every 4 cycles
        tw = 8'd3;
        fork
            begin
                for (int k = 0; k < 40; k++) begin
                    slow_en = (k % 4 == 3);
                    @(negedge clk);
                end
            end
            begin
                fire(0);
                trig_len(n);
            end
        join
        slow_en = 1'b1;
        chk("R3 slow span", (n >= 9 && n <= 12) ? 1 : 0, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule